// File: doc/BRIEF.md
# Instruction Count Trigger

This block is one debug trigger that counts retired instructions down to zero. Software loads a control word holding a 14-bit remaining-count field and a set of per-privilege enable bits. Each retire pulse that arrives while the hart runs in an enabled privilege mode takes one off the count. When the count steps from one to zero, the block raises a one-cycle breakpoint request toward the exception logic. The same control word is read back live, so software always sees how many instructions remain.

Control is held in a small state machine with three states. In `ST_DISARMED` the count is zero and retires have no effect. In `ST_COUNTING` the count is nonzero and enabled retires step it down. `ST_FIRE` lasts exactly one cycle and drives the breakpoint request.

The transitions are as follows. `ST_DISARMED` moves to `ST_COUNTING` on a write with a nonzero count. `ST_COUNTING` stays where it is on a write with a nonzero count, on a non-final step, or when nothing happens. `ST_COUNTING` moves to `ST_DISARMED` on a write with a zero count. `ST_COUNTING` moves to `ST_FIRE` on an enabled retire while the count is one. `ST_FIRE` moves to `ST_COUNTING` on a write with a nonzero count, and otherwise moves to `ST_DISARMED`.

Top module: `icnt_trigger`

## Requirements
- R1: After reset the read word equals 0x3000_0000: the type field in bits 31:28 holds 3 and every other bit, including the count, reads zero. `brk_fire` is low.
- R2: A write keeps only the enable bits and the count field. The enable bits are U at bit 6, S at bit 7, M at bit 9, VU at bit 25 and VS at bit 26, and the count occupies bits 23:10. The type field always reads 3. Every other bit, including the action bits 5:0, always reads zero.
- R3: A retire pulse in an enabled mode with a nonzero count lowers the count by exactly one. The new value is visible on `cfg_rdata` in the cycle after the clock edge.
- R4: With `virt`=0, the mode for `priv` 0 is enabled by U, 1 by S and 3 by M. With `virt`=1, the mode for `priv` 0 is enabled by VU and 1 by VS. A retire in a mode whose bit is clear leaves the count unchanged.
- R5: While the count is zero, retire pulses change nothing and no breakpoint is raised.
- R6: An enabled retire that takes the count from one to zero raises `brk_fire` for exactly one cycle, in the cycle after that edge.
- R7: A write in the same cycle as a retire pulse wins: the count takes the written value, nothing is subtracted, and no breakpoint results.
- R8: With no retire pulse and no write, the count holds its value.
- R9: `priv`=2 is never enabled, and with `virt`=1 neither is `priv`=2 or 3, whatever the enable bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Live control word, including the remaining count |
| retire | input | 1 | One pulse per retired instruction |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virt | input | 1 | Hart runs virtualised |
| brk_fire | output | 1 | One-cycle breakpoint request |

## Verification
Two functions can fall in the same cycle: a software write and a retire decrement. The bench provokes this by raising `cfg_wr` and `retire` together at one edge, once while the count is partway down and once while it sits at one. It judges the result by the read-back count, which must equal the written value. It also checks that `brk_fire` stays low, which shows the write pre-empted the final step. A full sweep of every privilege, virtualisation flag and enable mask checks the mode gating.

// File: rtl/icnt_pkg.sv
package icnt_pkg;

    localparam int DATA_W    = 32;
    localparam int CNT_WIDTH = 14;
    localparam int CNT_POS   = 10;
    localparam int TYPE_POS  = 28;
    localparam int TYPE_W    = 4;
    localparam logic [TYPE_W-1:0] TYPE_ICOUNT = 4'd3;

    localparam int BIT_U  = 6;
    localparam int BIT_S  = 7;
    localparam int BIT_M  = 9;
    localparam int BIT_VU = 25;
    localparam int BIT_VS = 26;

    typedef enum logic [1:0] {
        PRIV_USER    = 2'd0,
        PRIV_SUPER   = 2'd1,
        PRIV_RSVD    = 2'd2,
        PRIV_MACHINE = 2'd3
    } priv_e;

    typedef struct packed {
        logic vs;
        logic vu;
        logic m;
        logic s;
        logic u;
    } mode_en_t;

    typedef enum logic [1:0] {
        ST_DISARMED = 2'd0,
        ST_COUNTING = 2'd1,
        ST_FIRE     = 2'd2
    } state_e;

endpackage

// File: rtl/icnt_priv_gate.sv
module icnt_priv_gate
    import icnt_pkg::*;
(
    input  mode_en_t   en,
    input  logic [1:0] priv,
    input  logic       virt,
    output logic       allow
);

    priv_e level;

    always_comb begin
        level = priv_e'(priv);
        allow = 1'b0;
        if (virt) begin
            unique case (level)
                PRIV_USER:  allow = en.vu;
                PRIV_SUPER: allow = en.vs;
                default:    allow = 1'b0;
            endcase
        end else begin
            unique case (level)
                PRIV_USER:    allow = en.u;
                PRIV_SUPER:   allow = en.s;
                PRIV_MACHINE: allow = en.m;
                default:      allow = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/icnt_counter.sv
module icnt_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             is_one
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - ONE;
        end
    end

    assign is_one = (cnt == ONE);

endmodule

// File: rtl/icnt_fsm.sv
module icnt_fsm
    import icnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_nz,
    input  logic step,
    input  logic is_one,
    output logic dec,
    output logic fire
);

    state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_DISARMED;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_DISARMED: begin
                if (load && load_nz) state_nx = ST_COUNTING;
            end
            ST_COUNTING: begin
                if (load)                  state_nx = load_nz ? ST_COUNTING : ST_DISARMED;
                else if (step && is_one)   state_nx = ST_FIRE;
            end
            ST_FIRE: begin
                state_nx = (load && load_nz) ? ST_COUNTING : ST_DISARMED;
            end
            default: state_nx = ST_DISARMED;
        endcase
    end

    always_comb begin
        dec  = 1'b0;
        fire = 1'b0;
        unique case (state)
            ST_DISARMED: ;
            ST_COUNTING: dec  = step && !load;
            ST_FIRE:     fire = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/icnt_trigger.sv
module icnt_trigger
    import icnt_pkg::*;
#(
    parameter int XLEN    = DATA_W,
    parameter int CNT_W   = CNT_WIDTH,
    parameter int CNT_LSB = CNT_POS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [XLEN-1:0] cfg_wdata,
    output logic [XLEN-1:0] cfg_rdata,
    input  logic            retire,
    input  logic [1:0]      priv,
    input  logic            virt,
    output logic            brk_fire
);

    localparam int CNT_MSB = CNT_LSB + CNT_W - 1;

    mode_en_t          mode_en;
    logic              priv_ok;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_one;
    logic              do_dec;
    logic              load_nz;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_en <= '0;
        end else if (cfg_wr) begin
            mode_en.u  <= cfg_wdata[BIT_U];
            mode_en.s  <= cfg_wdata[BIT_S];
            mode_en.m  <= cfg_wdata[BIT_M];
            mode_en.vu <= cfg_wdata[BIT_VU];
            mode_en.vs <= cfg_wdata[BIT_VS];
        end
    end

    assign load_nz = |cfg_wdata[CNT_MSB:CNT_LSB];

    icnt_priv_gate u_gate (
        .en    (mode_en),
        .priv  (priv),
        .virt  (virt),
        .allow (priv_ok)
    );

    icnt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_wr),
        .load_val (cfg_wdata[CNT_MSB:CNT_LSB]),
        .dec      (do_dec),
        .cnt      (cnt),
        .is_one   (cnt_one)
    );

    icnt_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_wr),
        .load_nz (load_nz),
        .step    (retire && priv_ok),
        .is_one  (cnt_one),
        .dec     (do_dec),
        .fire    (brk_fire)
    );

    always_comb begin
        cfg_rdata                           = '0;
        cfg_rdata[TYPE_POS +: TYPE_W]       = TYPE_ICOUNT;
        cfg_rdata[BIT_U]                    = mode_en.u;
        cfg_rdata[BIT_S]                    = mode_en.s;
        cfg_rdata[BIT_M]                    = mode_en.m;
        cfg_rdata[BIT_VU]                   = mode_en.vu;
        cfg_rdata[BIT_VS]                   = mode_en.vs;
        cfg_rdata[CNT_MSB:CNT_LSB]          = cnt;
    end

endmodule

// File: rtl/icnt_trigger_chk.sv
module icnt_trigger_chk
    import icnt_pkg::*;
#(
    parameter int XLEN    = DATA_W,
    parameter int CNT_W   = CNT_WIDTH,
    parameter int CNT_LSB = CNT_POS
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_wr,
    input logic [XLEN-1:0] cfg_wdata,
    input logic [XLEN-1:0] cfg_rdata,
    input logic            retire,
    input logic            priv_ok,
    input logic            brk_fire
);

    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_rd;
    assign cnt_rd = cfg_rdata[CNT_LSB +: CNT_W];

    p_type_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[TYPE_POS +: TYPE_W] == TYPE_ICOUNT);

    p_action_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[5:0] == 6'd0);

    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && retire && priv_ok && cnt_rd != '0) |=> (cnt_rd == $past(cnt_rd) - C_ONE));

    p_gate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && !priv_ok) |=> $stable(cnt_rd));

    p_zero_stuck_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && cnt_rd == '0) |=> (cnt_rd == '0));

    p_fire_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_fire |=> !brk_fire);

    p_fire_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && retire && priv_ok && cnt_rd == C_ONE) |=> brk_fire);

    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cnt_rd == $past(cfg_wdata[CNT_LSB +: CNT_W])) && !brk_fire);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && !retire) |=> $stable(cnt_rd) && !brk_fire);

endmodule

bind icnt_trigger icnt_trigger_chk #(
    .XLEN    (XLEN),
    .CNT_W   (CNT_W),
    .CNT_LSB (CNT_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .retire    (retire),
    .priv_ok   (priv_ok),
    .brk_fire  (brk_fire)
);

// File: tb/icnt_trigger_test.sv
module icnt_trigger_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        retire = 1'b0;
    logic [1:0]  priv = 2'd3;
    logic        virt = 1'b0;
    logic        brk_fire;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icnt_trigger uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .retire    (retire),
        .priv      (priv),
        .virt      (virt),
        .brk_fire  (brk_fire)
    );

    // mask bit order: [0]=U [1]=S [2]=M [3]=VU [4]=VS
    function automatic logic [31:0] make_word(input logic [4:0] mask, input logic [13:0] cnt);
        logic [31:0] w;
        w = 32'h3000_0000;
        w[6]  = mask[0];
        w[7]  = mask[1];
        w[9]  = mask[2];
        w[25] = mask[3];
        w[26] = mask[4];
        w[23:10] = cnt;
        return w;
    endfunction

    function automatic bit mode_on(input logic [4:0] mask, input logic [1:0] p, input logic v);
        if (v) return (p == 2'd0) ? mask[3] : (p == 2'd1) ? mask[4] : 1'b0;
        case (p)
            2'd0: return mask[0];
            2'd1: return mask[1];
            2'd3: return mask[2];
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] w);
        cfg_wr = 1'b1;
        cfg_wdata = w;
        tick();
        cfg_wr = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 word", cfg_rdata, 32'h3000_0000);
        check("R1 fire", {31'd0, brk_fire}, 32'd0);
        rst_n = 1'b1;
        tick();
        check("R1 after release", cfg_rdata, 32'h3000_0000);

        // R2 all-ones write keeps only enables and count
        wr(32'hFFFF_FFFF);
        check("R2 masked", cfg_rdata, 32'h36FF_FEC0);
        wr(32'h0000_003F);
        check("R2 action bits", cfg_rdata, 32'h3000_0000);

        // R4 R9 R3 full sweep of mode gating
        for (int v = 0; v < 2; v++) begin
            for (int p = 0; p < 4; p++) begin
                for (int m = 0; m < 32; m++) begin
                    priv = 2'(p);
                    virt = 1'(v);
                    wr(make_word(5'(m), 14'd3));
                    check("R2 readback", cfg_rdata, make_word(5'(m), 14'd3));
                    retire = 1'b1;
                    tick();
                    retire = 1'b0;
                    check(mode_on(5'(m), 2'(p), 1'(v)) ? "R3 step" : "R4 R9 gated",
                          cfg_rdata,
                          make_word(5'(m), 14'd3 - 14'(mode_on(5'(m), 2'(p), 1'(v)))));
                    check("R6 no fire", {31'd0, brk_fire}, 32'd0);
                end
            end
        end

        // R6 countdown from 5 in machine mode
        priv = 2'd3;
        virt = 1'b0;
        wr(make_word(5'b00100, 14'd5));
        for (int i = 0; i < 5; i++) begin
            retire = 1'b1;
            tick();
            check("R3 countdown", cfg_rdata, make_word(5'b00100, 14'(4 - i)));
            check("R6 fire timing", {31'd0, brk_fire}, {31'd0, 1'(i == 4)});
        end
        tick();
        check("R6 single pulse", {31'd0, brk_fire}, 32'd0);
        check("R5 held at zero", cfg_rdata, make_word(5'b00100, 14'd0));
        tick();
        tick();
        retire = 1'b0;
        check("R5 no refire", {31'd0, brk_fire}, 32'd0);
        check("R5 still zero", cfg_rdata, make_word(5'b00100, 14'd0));

        // R8 hold without retire
        wr(make_word(5'b00100, 14'd7));
        tick();
        tick();
        tick();
        check("R8 hold", cfg_rdata, make_word(5'b00100, 14'd7));

        // R7 write during retire, mid-count
        retire = 1'b1;
        wr(make_word(5'b00100, 14'd9));
        retire = 1'b0;
        check("R7 write wins", cfg_rdata, make_word(5'b00100, 14'd9));

        // R7 write during final step: no fire
        wr(make_word(5'b00100, 14'd1));
        retire = 1'b1;
        wr(make_word(5'b00100, 14'd0));
        retire = 1'b0;
        check("R7 zero load", cfg_rdata, make_word(5'b00100, 14'd0));
        check("R7 no fire", {31'd0, brk_fire}, 32'd0);
        tick();
        check("R7 no late fire", {31'd0, brk_fire}, 32'd0);

        // R3 largest count
        wr(make_word(5'b00100, 14'h3FFF));
        retire = 1'b1;
        tick();
        retire = 1'b0;
        check("R3 max count", cfg_rdata, make_word(5'b00100, 14'h3FFE));

        // R6 fire in virtual user mode from count 1
        priv = 2'd0;
        virt = 1'b1;
        wr(make_word(5'b01000, 14'd1));
        retire = 1'b1;
        tick();
        retire = 1'b0;
        check("R6 virt fire", {31'd0, brk_fire}, 32'd1);
        check("R6 virt zero", cfg_rdata, make_word(5'b01000, 14'd0));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule